// File: doc/BRIEF.md
# Programmable Tap-Select Binary Timer

This block is a 16-stage binary up-counter whose output is taken from one of four selectable counter stages. It serves two uses. As a frequency divider, the chosen stage is passed straight to the output, which gives a square wave at the clock rate divided by 2^N. As a single-transition timer, the output makes one transition 2^(N-1) clocks after reset and then holds it. A polarity input sets whether the output rests low or high after reset.

Reset can come from three sources. A synchronous power-present input holds the block cleared while it is low. An optional power-up pulse is generated when that input rises, provided the auto-reset enable (active low) is asserted. An active-high master reset can be applied at any time. When the auto-reset is disabled, the counter stays idle after power-up until a master reset pulse has been applied and released. A clock-enable output goes low during every reset, so an external oscillator model can be gated off.

Top module: `prog_tap_timer`

## Requirements
- R1: While counting is enabled and no reset is active, the counter advances by one on each rising clock edge. A master reset clears the counter and the output latch, so the output timing restarts from zero after the reset is released.
- R2: The time-select code picks stage N, which is counter bit N-1. The codes are 2'b00 for N=13, 2'b01 for N=10, 2'b10 for N=8 and 2'b11 for N=16.
- R3: With recycle=1 the output follows stage N. It is a square wave with a period of 2^N clocks, and each level lasts 2^(N-1) clocks.
- R4: With recycle=0 the output rests at its reset level. After the edge that brings the count to 2^(N-1) following reset release, it moves to the opposite level. It keeps that level until a reset or until recycle=1.
- R5: inv_sel=1 inverts the output in both modes, so the output is high after reset. inv_sel=0 gives a low output after reset.
- R6: With auto_rst_n=0, the first rising edge at which por_n is sampled high is an internal one-cycle reset. Counting starts on the following edge.
- R7: With auto_rst_n=1, no power-up reset is generated. The counter stays at zero, and the output stays at its reset level, until a master reset pulse has been applied. Counting starts on the first edge after the pulse is released.
- R8: clk_en is low whenever por_n is low, mst_rst is high or the power-up reset pulse is pending. It is high otherwise.
- R9: A change of tsel reaches the output only after the next rising clock edge.
- R10: While por_n is low, the counter and latch are held cleared and the output is at its reset level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| por_n | input | 1 | Power-present, low holds the block cleared |
| auto_rst_n | input | 1 | Low enables the power-up reset pulse |
| mst_rst | input | 1 | Master reset, active high |
| tsel | input | 2 | Stage select code |
| recycle | input | 1 | 1 selects divider mode, 0 selects single-transition mode |
| inv_sel | input | 1 | 1 inverts the output |
| tmr_out | output | 1 | Timer output |
| clk_en | output | 1 | Low while any reset is active |

## Verification
A counter that skips or stalls shifts every transition of tmr_out. With N=8, the error shows within 128 clocks of a reset release. A latch that drops, or that sets early, gives a single-transition output that changes before or after the 2^(N-1) mark, or moves back before the next reset. A wrong select register or a wrong tap decode shows as a wrong rise latency, or as an output that changes in the same cycle as tsel. A fault in the power-up or arming logic shows as an output that starts counting when it should stay idle, or as clk_en staying high during the power-up pulse, and it shows within a few cycles of por_n rising.

// File: rtl/timer_pkg.sv
package timer_pkg;
   typedef logic [1:0] tsel_t;

   // stage number for a select code; the order is the decode the block relies on
   function automatic int unsigned stage_of(input tsel_t s,
                                            input int unsigned t0, input int unsigned t1,
                                            input int unsigned t2, input int unsigned t3);
      case (s)
         2'b00:   return t0;
         2'b01:   return t1;
         2'b10:   return t2;
         default: return t3;
      endcase
   endfunction
endpackage

// File: rtl/timer_reset_ctl.sv
module timer_reset_ctl (
   input  logic clk,
   input  logic por_n,
   input  logic auto_rst_n,
   input  logic mst_rst,
   output logic rst_any,
   output logic armed,
   output logic clk_en
);
   logic por_q;
   logic por_pulse;

   always_ff @(posedge clk) por_q <= por_n;

   assign por_pulse = por_n & ~por_q & ~auto_rst_n;
   assign rst_any   = ~por_n | mst_rst | por_pulse;
   assign clk_en    = ~rst_any;

   always_ff @(posedge clk) begin
      if (!por_n)                    armed <= 1'b0;
      else if (mst_rst || por_pulse) armed <= 1'b1;
   end

   // R8: master reset always gates the clock source
   a_r8_gate_in_reset: assert property (@(posedge clk) mst_rst |-> !clk_en);
   // R8: power absent also gates it
   a_r8_gate_no_power: assert property (@(posedge clk) !por_n |-> !clk_en);
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt
);
   initial begin
      if (W < 2) $error("timer_counter: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (clr)     cnt <= '0;
      else if (en) cnt <= cnt + 1'b1;
   end

   // R1: one step per enabled edge
   a_r1_step: assert property (@(posedge clk) disable iff (clr)
      en |=> (cnt == $past(cnt) + 1'b1));
   // R7: idle counter does not move
   a_r7_idle_holds: assert property (@(posedge clk) disable iff (clr)
      !en |=> (cnt == $past(cnt)));
endmodule

// File: rtl/timer_tap_mux.sv
module timer_tap_mux
   import timer_pkg::*;
#(
   parameter int unsigned W       = 16,
   parameter int unsigned TAP_S00 = 13,
   parameter int unsigned TAP_S01 = 10,
   parameter int unsigned TAP_S10 = 8,
   parameter int unsigned TAP_S11 = 16,
   parameter bit          REG_SEL = 1'b1
) (
   input  logic         clk,
   input  tsel_t        tsel,
   input  logic [W-1:0] cnt,
   output logic         stage_bit
);
   localparam int unsigned NSEL = 4;
   localparam int unsigned TAPS [NSEL] = '{TAP_S00, TAP_S01, TAP_S10, TAP_S11};

   logic [NSEL-1:0] cand;
   tsel_t           sel_use;

   for (genvar g = 0; g < NSEL; g++) begin : g_tap
      initial begin
         if (TAPS[g] < 1 || TAPS[g] > W)
            $error("timer_tap_mux: tap %0d out of range 1..%0d", TAPS[g], W);
      end
      assign cand[g] = cnt[TAPS[g]-1];
   end

   if (REG_SEL) begin : g_reg_sel
      tsel_t sel_q;
      always_ff @(posedge clk) sel_q <= tsel;
      assign sel_use = sel_q;
   end else begin : g_comb_sel
      assign sel_use = tsel;
   end

   assign stage_bit = cand[sel_use];
endmodule

// File: rtl/timer_out_stage.sv
module timer_out_stage (
   input  logic clk,
   input  logic rst_any,
   input  logic recycle,
   input  logic inv_sel,
   input  logic stage_bit,
   output logic tmr_out
);
   logic latch;
   logic rst_q;

   always_ff @(posedge clk) begin
      if (rst_any || recycle) latch <= 1'b0;
      else if (stage_bit)     latch <= 1'b1;
   end

   always_ff @(posedge clk) rst_q <= rst_any;

   assign tmr_out = (recycle ? stage_bit : (latch | stage_bit)) ^ inv_sel;

   // R4: a set latch holds while single-transition mode stays selected
   a_r4_latch_holds: assert property (@(posedge clk) disable iff (rst_any)
      (latch && !recycle) |=> latch);
   // R5: reset level right after a reset edge follows the polarity input
   a_r5_reset_level: assert property (@(posedge clk)
      rst_q |-> (tmr_out == inv_sel));
endmodule

// File: rtl/prog_tap_timer.sv
module prog_tap_timer
   import timer_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned TAP_S00 = 13,
   parameter int unsigned TAP_S01 = 10,
   parameter int unsigned TAP_S10 = 8,
   parameter int unsigned TAP_S11 = 16,
   parameter bit          REG_SEL = 1'b1
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       auto_rst_n,
   input  logic       mst_rst,
   input  logic [1:0] tsel,
   input  logic       recycle,
   input  logic       inv_sel,
   output logic       tmr_out,
   output logic       clk_en
);
   logic             rst_any;
   logic             armed;
   logic [CNT_W-1:0] cnt;
   logic             stage_bit;

   timer_reset_ctl u_rst (
      .clk        (clk),
      .por_n      (por_n),
      .auto_rst_n (auto_rst_n),
      .mst_rst    (mst_rst),
      .rst_any    (rst_any),
      .armed      (armed),
      .clk_en     (clk_en)
   );

   timer_counter #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .clr (rst_any),
      .en  (armed),
      .cnt (cnt)
   );

   timer_tap_mux #(
      .W       (CNT_W),
      .TAP_S00 (TAP_S00),
      .TAP_S01 (TAP_S01),
      .TAP_S10 (TAP_S10),
      .TAP_S11 (TAP_S11),
      .REG_SEL (REG_SEL)
   ) u_mux (
      .clk       (clk),
      .tsel      (tsel_t'(tsel)),
      .cnt       (cnt),
      .stage_bit (stage_bit)
   );

   timer_out_stage u_out (
      .clk       (clk),
      .rst_any   (rst_any),
      .recycle   (recycle),
      .inv_sel   (inv_sel),
      .stage_bit (stage_bit),
      .tmr_out   (tmr_out)
   );

   // R10: power absent keeps the count cleared on the next edge
   a_r10_power_clear: assert property (@(posedge clk) !por_n |=> (cnt == '0));
endmodule

// File: tb/test_prog_tap_timer.sv
module test_prog_tap_timer;
   logic       clk = 1'b0;
   logic       por_n = 1'b0, auto_rst_n = 1'b0, mst_rst = 1'b0;
   logic [1:0] tsel = 2'b10;
   logic       recycle = 1'b0, inv_sel = 1'b0;
   logic       tmr_out, clk_en;

   int nchk = 0, nerr = 0, cyc = 0;
   bit chk_on = 1'b0;

   // bench model state
   logic [15:0] m_cnt = '0;
   logic        m_latch = 1'b0, m_armed = 1'b0, m_porq = 1'b0;
   logic [1:0]  m_sel = 2'b00;

   always #4 clk = ~clk;

   prog_tap_timer i_prog_tap_timer (
      .clk(clk), .por_n(por_n), .auto_rst_n(auto_rst_n), .mst_rst(mst_rst),
      .tsel(tsel), .recycle(recycle), .inv_sel(inv_sel),
      .tmr_out(tmr_out), .clk_en(clk_en));

   function automatic int tap_of(input logic [1:0] s);
      case (s)
         2'b00:   return 13;
         2'b01:   return 10;
         2'b10:   return 8;
         default: return 16;
      endcase
   endfunction

   function automatic logic m_bit();
      return m_cnt[tap_of(m_sel)-1];
   endfunction

   function automatic logic exp_out();
      return (recycle ? m_bit() : (m_latch | m_bit())) ^ inv_sel;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic report();
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   // model update from the requirement text
   always @(posedge clk) begin
      logic pulse, rst;
      pulse = por_n & ~m_porq & ~auto_rst_n;
      rst   = ~por_n | mst_rst | pulse;
      m_porq <= por_n;
      m_sel  <= tsel;
      if (!por_n)               m_armed <= 1'b0;
      else if (mst_rst | pulse) m_armed <= 1'b1;
      if (rst)          m_cnt <= '0;
      else if (m_armed) m_cnt <= m_cnt + 16'd1;
      if (rst || recycle) m_latch <= 1'b0;
      else if (m_bit())   m_latch <= 1'b1;
   end

   // per-cycle compare, away from both edges; watchdog
   always @(posedge clk) begin
      #2;
      cyc++;
      if (chk_on) begin
         logic ce;
         ce = por_n & ~mst_rst & ~(por_n & ~m_porq & ~auto_rst_n);
         chk(tmr_out == exp_out(), recycle ? "R3 cycle" : "R4 cycle", tmr_out, exp_out());
         chk(clk_en == ce, "R8 cycle", clk_en, ce);
      end
      if (cyc > 190000) begin
         chk(1'b0, "watchdog", cyc, 190000);
         report();
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_mr();
      mst_rst = 1'b1;
      step(1);
      mst_rst = 1'b0;
   endtask

   task automatic measure(output int n, input int lim);
      logic l0;
      l0 = tmr_out;
      n = 0;
      while (tmr_out == l0 && n < lim) begin
         step(1);
         n++;
      end
   endtask

   initial begin
      int n;
      void'($urandom(32'd4541));
      step(3);
      chk_on = 1'b1;
      // R10: held cleared while power absent
      chk(tmr_out == 1'b0, "R10 reset level", tmr_out, 0);
      chk(clk_en == 1'b0, "R10 clk_en low", clk_en, 0);

      // R6: power-up with auto reset enabled, N=8 single transition
      por_n = 1'b1;
      #1 chk(clk_en == 1'b0, "R6 power-up pulse gates clock", clk_en, 0);
      step(1);
      chk(clk_en == 1'b1, "R8 clk_en after pulse", clk_en, 1);
      measure(n, 1000);
      chk(n == 128, "R6 count after power-up", n, 128);
      step(300);
      chk(tmr_out == 1'b1, "R4 output holds", tmr_out, 1);

      // R2: single-transition latency for each select code
      for (int s = 0; s < 4; s++) begin
         tsel = 2'(s);
         step(1);
         pulse_mr();
         measure(n, 70000);
         chk(n == (1 << (tap_of(2'(s)) - 1)), "R2 stage decode", n, 1 << (tap_of(2'(s)) - 1));
      end

      // R5: inverted single transition, N=10
      inv_sel = 1'b1; tsel = 2'b01;
      step(1);
      pulse_mr();
      chk(tmr_out == 1'b1, "R5 inverted reset level", tmr_out, 1);
      measure(n, 2000);
      chk(n == 512, "R5 inverted latency", n, 512);
      chk(tmr_out == 1'b0, "R5 inverted final level", tmr_out, 0);

      // R3: divider mode N=8, three half periods
      inv_sel = 1'b0; recycle = 1'b1; tsel = 2'b10;
      step(1);
      pulse_mr();
      for (int k = 0; k < 3; k++) begin
         measure(n, 1000);
         chk(n == 128, "R3 half period", n, 128);
      end

      // R9: select change reaches output only after the next edge
      pulse_mr();
      step(128);
      chk(tmr_out == 1'b1, "R9 precondition", tmr_out, 1);
      tsel = 2'b00;
      #1 chk(tmr_out == 1'b1, "R9 no change before edge", tmr_out, 1);
      step(1);
      chk(tmr_out == 1'b0, "R9 new stage after edge", tmr_out, 0);

      // R1: reset in mid-count restarts the timing
      recycle = 1'b0; tsel = 2'b10;
      step(1);
      pulse_mr();
      step(100);
      pulse_mr();
      measure(n, 1000);
      chk(n == 128, "R1 restart after master reset", n, 128);

      // R8: clock enable during master reset
      mst_rst = 1'b1;
      #1 chk(clk_en == 1'b0, "R8 clk_en low in reset", clk_en, 0);
      step(1);
      chk(clk_en == 1'b0, "R8 clk_en still low", clk_en, 0);
      mst_rst = 1'b0;
      #1 chk(clk_en == 1'b1, "R8 clk_en high after release", clk_en, 1);

      // R7: auto reset disabled, idle until master reset
      step(1);
      por_n = 1'b0; auto_rst_n = 1'b1;
      step(2);
      por_n = 1'b1;
      #1 chk(clk_en == 1'b1, "R7 no power-up pulse", clk_en, 1);
      step(400);
      chk(tmr_out == 1'b0, "R7 idle before master reset", tmr_out, 0);
      pulse_mr();
      measure(n, 1000);
      chk(n == 128, "R7 counting after master reset", n, 128);

      // random segments checked by the per-cycle model
      for (int seg = 0; seg < 40; seg++) begin
         tsel    = 2'($urandom % 4);
         recycle = 1'($urandom % 2);
         inv_sel = 1'($urandom % 2);
         if ($urandom % 8 == 0) begin
            por_n = 1'b0;
            auto_rst_n = 1'($urandom % 2);
            step(2);
            por_n = 1'b1;
         end
         if ($urandom % 3 == 0) pulse_mr();
         step(1 + int'($urandom % 800));
      end
      report();
   end
endmodule